// File: doc/BRIEF.md
# First-Error Capture Status Register

This block is the error log of a bus bridge that has a north side and a south side. Each side can signal an error event as a single-cycle pulse. The pulse carries three things: the identifier of the initiator whose transaction failed, whether that transaction was a read or a write, and a two-bit error class.

The register keeps a snapshot of the first error it sees and nothing after it. Any later error only raises a sticky overflow flag. A level interrupt, gated by a software enable bit, stays high while either flag is set. Software reads the 32-bit register through a simple read/write strobe port. The read returns the current contents and clears the two flag bits on the following cycle. The logged fields hold their values until the next capture.

Top module: `err_first_capture`

## Requirements
- R1: After reset the register reads 0x0000_0000 and `irq` is low.
- R2: An error pulse that arrives while bit 0 is clear is captured, and bit 0 reads 1 from the next cycle.
- R3: An error pulse that arrives while bit 0 is set changes none of bits 11:2 and sets bit 1.
- R4: Captured field layout: bits 11:8 hold the requester ID, bit 5 the side (0 north, 1 south), bit 4 the command (0 read, 1 write), and bits 3:2 the error class.
- R5: A read strobe returns the register value held in that cycle and clears bits 1:0 from the next cycle. Bits 11:2 and bit 16 are kept.
- R6: If an error arrives in the same cycle as a read strobe, the clear is applied first. The error is then logged as a new first error, so bit 0 reads 1 and bit 1 reads 0.
- R7: If both sides report an error in the same cycle while bit 0 is clear, the north event is captured and bit 1 is set.
- R8: A write strobe loads only bit 16 (the interrupt enable) from the write data. Bits 11:0 cannot be written, and bits 31:17, 15:12 and 7:6 always read 0.
- R9: `irq` equals bit 16 AND (bit 0 OR bit 1), as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears bits 1:0) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register contents |
| n_err_vld | input | 1 | North-side error pulse |
| n_err_id | input | 4 | North requester ID |
| n_err_wr | input | 1 | North command: 1 write, 0 read |
| n_err_type | input | 2 | North error class |
| s_err_vld | input | 1 | South-side error pulse |
| s_err_id | input | 4 | South requester ID |
| s_err_wr | input | 1 | South command: 1 write, 0 read |
| s_err_type | input | 2 | South error class |
| irq | output | 1 | Level interrupt |

## Verification
The bench covers each of the following corner cases:
- **Second error while the log is full.** A design that overwrites the log would show the later error's ID and side instead of only setting the overflow flag.
- **Error in the same cycle as a read.** This exposes a design that ranks set over clear: it would keep the old snapshot and report an overflow instead of a fresh first error.
- **Both sides reporting in the same cycle.** This catches wrong priority, which would log the south event, and a missed overflow flag.
- **All-ones writes and enable-off errors.** These show whether logged fields or flags can be written, and whether the interrupt ignores its enable.

// File: rtl/err_first_capture.sv
module err_first_capture #(
  parameter int ID_W   = 4,
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              n_err_vld,
  input  logic [ID_W-1:0]   n_err_id,
  input  logic              n_err_wr,
  input  logic [TYPE_W-1:0] n_err_type,
  input  logic              s_err_vld,
  input  logic [ID_W-1:0]   s_err_id,
  input  logic              s_err_wr,
  input  logic [TYPE_W-1:0] s_err_type,
  output logic              irq
);
  localparam int EN_BIT   = 16;
  localparam int ID_LSB   = 8;
  localparam int SIDE_BIT = 5;
  localparam int CMD_BIT  = 4;
  localparam int TYP_LSB  = 2;

  logic              first_q, multi_q, en_q, side_q, cmd_q;
  logic [ID_W-1:0]   id_q;
  logic [TYPE_W-1:0] typ_q;

  logic first_eff, multi_eff, any_err, take;
  logic [ID_W-1:0]   pick_id;
  logic              pick_wr, pick_side;
  logic [TYPE_W-1:0] pick_typ;

  assign first_eff = first_q & ~reg_rd;
  assign multi_eff = multi_q & ~reg_rd;
  assign any_err   = n_err_vld | s_err_vld;
  assign take      = any_err & ~first_eff;

  assign pick_side = ~n_err_vld;
  assign pick_id   = n_err_vld ? n_err_id   : s_err_id;
  assign pick_wr   = n_err_vld ? n_err_wr   : s_err_wr;
  assign pick_typ  = n_err_vld ? n_err_type : s_err_type;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      multi_q <= 1'b0;
      en_q    <= 1'b0;
      side_q  <= 1'b0;
      cmd_q   <= 1'b0;
      id_q    <= '0;
      typ_q   <= '0;
    end else begin
      if (reg_wr) en_q <= reg_wdata[EN_BIT];
      if (take) begin
        first_q <= 1'b1;
        multi_q <= multi_eff | (n_err_vld & s_err_vld);
        side_q  <= pick_side;
        cmd_q   <= pick_wr;
        id_q    <= pick_id;
        typ_q   <= pick_typ;
      end else begin
        first_q <= first_eff;
        multi_q <= multi_eff | any_err;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[EN_BIT]                = en_q;
    reg_rdata[ID_LSB +: ID_W]        = id_q;
    reg_rdata[SIDE_BIT]              = side_q;
    reg_rdata[CMD_BIT]               = cmd_q;
    reg_rdata[TYP_LSB +: TYPE_W]     = typ_q;
    reg_rdata[1]                     = multi_q;
    reg_rdata[0]                     = first_q;
  end

  assign irq = en_q & (first_q | multi_q);

  // R2
  a_r2_first_set: assert property (@(posedge clk) disable iff (!rst_n)
    (n_err_vld || s_err_vld) |=> reg_rdata[0]);
  // R3
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && !reg_rd) |=> $stable(reg_rdata[11:2]));
  // R5
  a_r5_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !n_err_vld && !s_err_vld) |=> (reg_rdata[1:0] == 2'b00));
  // R6
  a_r6_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (n_err_vld ^ s_err_vld)) |=> (reg_rdata[1:0] == 2'b01));
  // R7
  a_r7_north_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (n_err_vld && s_err_vld && (!reg_rdata[0] || reg_rd)) |=> (reg_rdata[1] && !reg_rdata[5]));
  // R8
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:17] == '0) && (reg_rdata[15:12] == '0) && (reg_rdata[7:6] == '0));
  // R9
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[16] |-> !irq);
endmodule

// File: tb/err_first_capture_bench.sv
module err_first_capture_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic n_err_vld = 1'b0, n_err_wr = 1'b0, s_err_vld = 1'b0, s_err_wr = 1'b0;
  logic [3:0] n_err_id = '0, s_err_id = '0;
  logic [1:0] n_err_type = '0, s_err_type = '0;
  logic irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  err_first_capture u_err_first_capture (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .n_err_vld(n_err_vld), .n_err_id(n_err_id), .n_err_wr(n_err_wr), .n_err_type(n_err_type),
    .s_err_vld(s_err_vld), .s_err_id(s_err_id), .s_err_wr(s_err_wr), .s_err_type(s_err_type),
    .irq(irq)
  );

  // monitor: pops expected items when a read is on the port
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (reg_rd && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (reg_rdata !== e.val) begin
          fails++;
          $display("FAIL %s: rdata actual %h expected %h", e.tag, reg_rdata, e.val);
        end
      end
    end
  end

  task automatic chk_irq(input logic exp, input string tag);
    #2;
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1;
    sb_q.push_back('{exp, tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic drive_err(input logic nv, input logic [3:0] nid, input logic nw, input logic [1:0] nt,
                           input logic sv, input logic [3:0] sid, input logic sw, input logic [1:0] st,
                           input logic with_rd, input logic [31:0] exp, input string tag);
    @(negedge clk);
    n_err_vld = nv; n_err_id = nid; n_err_wr = nw; n_err_type = nt;
    s_err_vld = sv; s_err_id = sid; s_err_wr = sw; s_err_type = st;
    if (with_rd) begin
      reg_rd = 1'b1;
      sb_q.push_back('{exp, tag});
    end
    @(negedge clk);
    n_err_vld = 1'b0; s_err_vld = 1'b0; reg_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_irq(1'b0, "R1");
    do_read(32'h0000_0000, "R1");

    do_write(32'hFFFF_FFFF);
    do_read(32'h0001_0000, "R8");

    // north id 3 read class 2
    drive_err(1'b1, 4'h3, 1'b0, 2'd2, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, '0, "");
    chk_irq(1'b1, "R9");
    do_read(32'h0001_0309, "R2_R4");
    chk_irq(1'b0, "R9");
    do_read(32'h0001_0308, "R5");

    // south id 9 write class 1, then north id 5 discarded
    drive_err(1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 4'h9, 1'b1, 2'd1, 1'b0, '0, "");
    drive_err(1'b1, 4'h5, 1'b0, 2'd3, 1'b0, 4'h0, 1'b0, 2'd0, 1'b0, '0, "");
    do_read(32'h0001_0937, "R3");
    do_read(32'h0001_0934, "R5");

    // enable off: error logged, no interrupt
    do_write(32'h0000_0000);
    drive_err(1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 4'hA, 1'b0, 2'd3, 1'b0, '0, "");
    chk_irq(1'b0, "R9");
    // read and new error together
    drive_err(1'b1, 4'h2, 1'b1, 2'd0, 1'b0, 4'h0, 1'b0, 2'd0, 1'b1, 32'h0000_0A2D, "R6");
    do_read(32'h0000_0211, "R6");

    // both sides at once with log empty
    drive_err(1'b1, 4'h7, 1'b0, 2'd1, 1'b1, 4'h1, 1'b1, 2'd2, 1'b0, '0, "");
    do_read(32'h0000_0707, "R7");
    do_read(32'h0000_0704, "R5");

    // all-ones write touches only the enable
    do_write(32'hFFFF_FFFF);
    do_read(32'h0001_0704, "R8");
    chk_irq(1'b0, "R9");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule